// File: doc/BRIEF.md
# Multi-Line Interrupt Vector Arbiter

This block gathers interrupt requests from a set of serial lines and presents them to a processor as two request levels. The receive level covers both received-data and modem-status events. The transmit level covers transmitter-ready events. Each line has its own set and clear strobes for each of its three request kinds, and the block keeps one pending bit per line and per kind.

When the processor acknowledges a level, the block picks the lowest-numbered line that has a pending request in that group. It returns that line's vector and clears the requests it has just served. Each line owns an eight-byte slot above a programmable vector base. The receive vector is at the start of the slot and the transmit vector sits 4 above it.

A receive-group acknowledge serves the received-data and modem-status requests of the winning line together, under one vector. The vector and a valid flag are registered and appear in the cycle after the acknowledge strobe. The number of lines is a parameter of at most 16.

Top module: `irqv_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, both request levels are low, vec_valid is 0 and vec_out is 0. Reset clears every pending request bit.
- R2: A set strobe on bit i of set_rx or set_ds, with no clear on that bit, makes irq_rx high from the next cycle. irq_rx stays high while any receive or modem-status bit is pending.
- R3: A set strobe on bit i of set_tx, with no clear on that bit, makes irq_tx high from the next cycle. irq_tx stays high while any transmit bit is pending.
- R4: On ack_rx, the winner is the lowest line i whose receive or modem-status bit is pending. In the next cycle vec_valid is 1 and vec_out is (vec_base + 8*i) mod 2^VEC_W, using vec_base as sampled in the acknowledge cycle. Both the receive and the modem-status bits of that line are cleared, and no other bit changes.
- R5: On ack_tx alone, the winner is the lowest line i whose transmit bit is pending. In the next cycle vec_valid is 1 and vec_out is (vec_base + 8*i + 4) mod 2^VEC_W. Only that line's transmit bit is cleared.
- R6: An acknowledge for a group that has no pending bit gives vec_out = 0 and vec_valid = 0 in the next cycle, and changes no pending bit.
- R7: In a cycle that follows one with neither acknowledge, vec_valid is 0 and vec_out is 0. The valid flag is a single-cycle pulse.
- R8: If a bit sees a set strobe and a clear in the same cycle, it ends up clear. The clear may come from its clear strobe or from being served by an acknowledge.
- R9: When ack_rx and ack_tx are high in the same cycle, only the receive group is served. The transmit bits are left as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_rx | input | NUM_LINES | Per-line received-data request set strobes |
| clr_rx | input | NUM_LINES | Per-line received-data request clear strobes |
| set_ds | input | NUM_LINES | Per-line modem-status request set strobes |
| clr_ds | input | NUM_LINES | Per-line modem-status request clear strobes |
| set_tx | input | NUM_LINES | Per-line transmitter-ready request set strobes |
| clr_tx | input | NUM_LINES | Per-line transmitter-ready request clear strobes |
| ack_rx | input | 1 | Acknowledge strobe for the receive group |
| ack_tx | input | 1 | Acknowledge strobe for the transmit group |
| vec_base | input | VEC_W | Vector base address |
| irq_rx | output | 1 | Receive-group master request |
| irq_tx | output | 1 | Transmit-group master request |
| vec_out | output | VEC_W | Vector returned for the last acknowledge |
| vec_valid | output | 1 | High for one cycle when vec_out holds a served vector |

## Verification
The bench targets a line with both a received-data and a modem-status request pending. A design that cleared only one of them would keep irq_rx high after a single acknowledge and would answer the same line twice.

It presents several lines at once to test the lowest-first scan. A design that scanned the wrong way, or used the line index without the 8-byte scaling or the transmit +4 offset, returns wrong vectors. A base near the top of the vector range checks that the result wraps instead of corrupting its low bits.

It also drives a set together with a clear, or together with the acknowledge that serves the same bit, and both acknowledges in one cycle. A design that let set win would leave a stale request behind. A design that served both groups at once would lose a transmit request without ever returning its vector.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Which request group an acknowledge cycle serves.
  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_RX   = 2'd1,
    GRP_TX   = 2'd2
  } grp_e;

  localparam int unsigned MAX_LINES  = 16;
  localparam int unsigned SLOT_SHIFT = 3;  // 8 bytes per line slot
  localparam int unsigned TX_OFFSET  = 4;  // transmit vector sits 4 above

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irqv_req_bank.sv
module irqv_req_bank #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  input  logic [NUM_LINES-1:0] serve_i,
  output logic [NUM_LINES-1:0] pend_o
);

  logic [NUM_LINES-1:0] pend_q;

  // One pending flop per line; any clear source beats a set.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
    logic kill;
    assign kill = clr_i[g] | serve_i[g];
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[g] <= 1'b0;
      end else if (kill) begin
        pend_q[g] <= 1'b0;
      end else if (set_i[g]) begin
        pend_q[g] <= 1'b1;
      end
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irqv_pick.sv
module irqv_pick #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [NUM_LINES-1:0] onehot_o
);

  // Isolate the lowest set bit, then encode it.
  logic [NUM_LINES-1:0] lowest;
  assign lowest = req_i & (~req_i + NUM_LINES'(1));
  assign hit_o  = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (lowest[i]) begin
        idx_o = idx_o | IDX_W'(i);
      end
    end
  end

  assign onehot_o = lowest;

endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen
  import irqv_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned VEC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  grp_e             grp_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VEC_W-1:0] base_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             valid_o
);

  localparam int unsigned OFS_W  = IDX_W + SLOT_SHIFT;
  localparam int unsigned WIDE_W = VEC_W + OFS_W;

  logic [OFS_W-1:0]  offset;
  logic [WIDE_W-1:0] sum;
  logic              is_tx;

  assign is_tx  = (grp_i == GRP_TX);
  assign offset = {idx_i, is_tx, 2'b00};
  assign sum    = WIDE_W'(base_i) + WIDE_W'(offset);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o   <= '0;
      valid_o <= 1'b0;
    end else if (grp_i != GRP_NONE) begin
      vec_o   <= sum[VEC_W-1:0];
      valid_o <= 1'b1;
    end else begin
      vec_o   <= '0;
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned VEC_W     = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] set_rx,
  input  logic [NUM_LINES-1:0] clr_rx,
  input  logic [NUM_LINES-1:0] set_ds,
  input  logic [NUM_LINES-1:0] clr_ds,
  input  logic [NUM_LINES-1:0] set_tx,
  input  logic [NUM_LINES-1:0] clr_tx,
  input  logic                 ack_rx,
  input  logic                 ack_tx,
  input  logic [VEC_W-1:0]     vec_base,
  output logic                 irq_rx,
  output logic                 irq_tx,
  output logic [VEC_W-1:0]     vec_out,
  output logic                 vec_valid
);

  localparam int unsigned IDX_W = idx_width(NUM_LINES);

  logic [NUM_LINES-1:0] rx_pend, ds_pend, tx_pend, rxg_pend;
  logic [NUM_LINES-1:0] rxg_low, tx_low;
  logic [NUM_LINES-1:0] rxg_serve, tx_serve;
  logic [IDX_W-1:0]     rxg_idx, tx_idx, win_idx;
  logic                 rxg_hit, tx_hit;
  logic                 take_rx, take_tx;
  grp_e                 grp;

  assign rxg_pend = rx_pend | ds_pend;

  irqv_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick_rx (
    .req_i(rxg_pend), .hit_o(rxg_hit), .idx_o(rxg_idx), .onehot_o(rxg_low)
  );

  irqv_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick_tx (
    .req_i(tx_pend), .hit_o(tx_hit), .idx_o(tx_idx), .onehot_o(tx_low)
  );

  // Receive group has precedence when both acknowledges coincide.
  assign take_rx   = ack_rx & rxg_hit;
  assign take_tx   = ack_tx & ~ack_rx & tx_hit;
  assign rxg_serve = take_rx ? rxg_low : '0;
  assign tx_serve  = take_tx ? tx_low : '0;
  assign win_idx   = take_rx ? rxg_idx : tx_idx;
  assign grp       = take_rx ? GRP_RX : (take_tx ? GRP_TX : GRP_NONE);

  irqv_req_bank #(.NUM_LINES(NUM_LINES)) u_bank_rx (
    .clk(clk), .rst(rst), .set_i(set_rx), .clr_i(clr_rx),
    .serve_i(rxg_serve), .pend_o(rx_pend)
  );

  irqv_req_bank #(.NUM_LINES(NUM_LINES)) u_bank_ds (
    .clk(clk), .rst(rst), .set_i(set_ds), .clr_i(clr_ds),
    .serve_i(rxg_serve), .pend_o(ds_pend)
  );

  irqv_req_bank #(.NUM_LINES(NUM_LINES)) u_bank_tx (
    .clk(clk), .rst(rst), .set_i(set_tx), .clr_i(clr_tx),
    .serve_i(tx_serve), .pend_o(tx_pend)
  );

  irqv_vecgen #(.IDX_W(IDX_W), .VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst(rst), .grp_i(grp), .idx_i(win_idx),
    .base_i(vec_base), .vec_o(vec_out), .valid_o(vec_valid)
  );

  assign irq_rx = |rxg_pend;
  assign irq_tx = |tx_pend;

endmodule

// File: rtl/irqv_arbiter_chk.sv
module irqv_arbiter_chk #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned VEC_W     = 9
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] set_rx,
  input logic [NUM_LINES-1:0] clr_rx,
  input logic [NUM_LINES-1:0] set_ds,
  input logic [NUM_LINES-1:0] clr_ds,
  input logic [NUM_LINES-1:0] set_tx,
  input logic [NUM_LINES-1:0] clr_tx,
  input logic                 ack_rx,
  input logic                 ack_tx,
  input logic [VEC_W-1:0]     vec_base,
  input logic                 irq_rx,
  input logic                 irq_tx,
  input logic [VEC_W-1:0]     vec_out,
  input logic                 vec_valid
);

  initial begin
    p_param_range_r4: assert (NUM_LINES >= 1 && NUM_LINES <= 16 && VEC_W >= 3)
      else $error("parameter out of range");
  end

  p_rx_raise_r2: assert property (@(posedge clk) disable iff (rst)
    (!ack_rx && (|(set_rx & ~clr_rx) || |(set_ds & ~clr_ds))) |=> irq_rx);

  p_tx_raise_r3: assert property (@(posedge clk) disable iff (rst)
    (!ack_tx && |(set_tx & ~clr_tx)) |=> irq_tx);

  p_rx_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_rx && irq_rx) |=> (vec_valid && vec_out[2:0] == $past(vec_base[2:0])));

  p_tx_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_tx && !ack_rx && irq_tx) |=>
      (vec_valid && vec_out[2:0] == 3'($past(vec_base[2:0]) + 3'd4)));

  p_empty_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_rx && !irq_rx) |=> (!vec_valid && vec_out == '0));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!ack_rx && !ack_tx) |=> (!vec_valid && vec_out == '0));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
    ((&clr_rx) && (&clr_ds)) |=> !irq_rx);

  p_tx_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_rx && ack_tx && irq_tx && clr_tx == '0) |=> irq_tx);

endmodule

bind irqv_arbiter irqv_arbiter_chk #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .set_rx(set_rx), .clr_rx(clr_rx), .set_ds(set_ds),
  .clr_ds(clr_ds), .set_tx(set_tx), .clr_tx(clr_tx), .ack_rx(ack_rx),
  .ack_tx(ack_tx), .vec_base(vec_base), .irq_rx(irq_rx), .irq_tx(irq_tx),
  .vec_out(vec_out), .vec_valid(vec_valid)
);

// File: tb/irqv_arbiter_tb.sv
`timescale 1ns/1ps
module irqv_arbiter_tb;

  localparam int N  = 16;
  localparam int VW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  set_rx = '0, clr_rx = '0, set_ds = '0, clr_ds = '0;
  logic [N-1:0]  set_tx = '0, clr_tx = '0;
  logic          ack_rx = 1'b0, ack_tx = 1'b0;
  logic [VW-1:0] vec_base = 9'h040;
  logic          irq_rx, irq_tx, vec_valid;
  logic [VW-1:0] vec_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  irqv_arbiter #(.NUM_LINES(N), .VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .set_rx(set_rx), .clr_rx(clr_rx), .set_ds(set_ds),
    .clr_ds(clr_ds), .set_tx(set_tx), .clr_tx(clr_tx), .ack_rx(ack_rx),
    .ack_tx(ack_tx), .vec_base(vec_base), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  // Behavioural reference model.
  bit    m_rx[N], m_ds[N], m_tx[N];
  int    e_vec   = 0;
  bit    e_valid = 0;
  string e_tag   = "R1";

  always @(posedge clk) begin
    int win;
    bit srv_rx, srv_tx;
    win = -1; srv_rx = 0; srv_tx = 0;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_rx[i] = 0; m_ds[i] = 0; m_tx[i] = 0; end
      e_vec = 0; e_valid = 0; e_tag = "R1";
    end else begin
      if (ack_rx) begin
        for (int i = N - 1; i >= 0; i--) if (m_rx[i] || m_ds[i]) win = i;
        if (win >= 0) begin
          srv_rx = 1;
          e_vec = (int'(vec_base) + 8 * win) % (1 << VW);
          e_valid = 1; e_tag = "R4";
        end else begin
          e_vec = 0; e_valid = 0; e_tag = "R6";
        end
      end else if (ack_tx) begin
        for (int i = N - 1; i >= 0; i--) if (m_tx[i]) win = i;
        if (win >= 0) begin
          srv_tx = 1;
          e_vec = (int'(vec_base) + 8 * win + 4) % (1 << VW);
          e_valid = 1; e_tag = "R5";
        end else begin
          e_vec = 0; e_valid = 0; e_tag = "R6";
        end
      end else begin
        e_vec = 0; e_valid = 0; e_tag = "R7";
      end
      for (int i = 0; i < N; i++) begin
        bit kr, kt;
        kr = srv_rx && (i == win);
        kt = srv_tx && (i == win);
        m_rx[i] = (m_rx[i] || set_rx[i]) && !clr_rx[i] && !kr;
        m_ds[i] = (m_ds[i] || set_ds[i]) && !clr_ds[i] && !kr;
        m_tx[i] = (m_tx[i] || set_tx[i]) && !clr_tx[i] && !kt;
      end
    end
  end

  function automatic bit any_rx();
    for (int i = 0; i < N; i++) if (m_rx[i] || m_ds[i]) return 1;
    return 0;
  endfunction

  function automatic bit any_tx();
    for (int i = 0; i < N; i++) if (m_tx[i]) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, one time unit after each edge.
  always @(posedge clk) begin
    #1;
    if (!done) begin
      check(rst ? "R1" : "R2", "irq_rx", int'(irq_rx), int'(any_rx()));
      check(rst ? "R1" : "R3", "irq_tx", int'(irq_tx), int'(any_tx()));
      check(e_tag, "vec_valid", int'(vec_valid), int'(e_valid));
      check(e_tag, "vec_out", int'(vec_out), e_vec);
    end
  end

  task automatic drv(input logic [N-1:0] srx, input logic [N-1:0] sds,
                     input logic [N-1:0] stx, input logic [N-1:0] crx,
                     input logic [N-1:0] cds, input logic [N-1:0] ctx,
                     input logic arx, input logic atx);
    @(negedge clk);
    set_rx = srx; set_ds = sds; set_tx = stx;
    clr_rx = crx; clr_ds = cds; clr_tx = ctx;
    ack_rx = arx; ack_tx = atx;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    drv('0, '0, '0, '0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset irq_rx", int'(irq_rx), 0);
    check("R1", "reset vec_valid", int'(vec_valid), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1", "post-reset irq_tx", int'(irq_tx), 0);
    check("R1", "post-reset vec_out", int'(vec_out), 0);

    // R2 / R4: lowest line first, with a modem-status request on line 3.
    drv(16'h0020, 16'h0008, '0, '0, '0, '0, 0, 0);
    check("R2", "irq_rx after set", int'(irq_rx), 1);
    check("R3", "irq_tx stays low", int'(irq_tx), 0);
    drv('0, '0, '0, '0, '0, '0, 1, 0);
    check("R4", "vec line3", int'(vec_out), 'h058);
    check("R4", "valid line3", int'(vec_valid), 1);
    drv('0, '0, '0, '0, '0, '0, 1, 0);
    check("R4", "vec line5", int'(vec_out), 'h068);
    check("R4", "irq_rx cleared", int'(irq_rx), 0);
    idle();
    check("R7", "valid pulse ends", int'(vec_valid), 0);

    // R4: both kinds on one line served by a single acknowledge.
    drv(16'h0080, 16'h0080, '0, '0, '0, '0, 0, 0);
    drv('0, '0, '0, '0, '0, '0, 1, 0);
    check("R4", "vec line7", int'(vec_out), 'h078);
    check("R4", "both kinds cleared", int'(irq_rx), 0);

    // R3 / R5: transmit vectors carry +4.
    drv('0, '0, 16'h0204, '0, '0, '0, 0, 0);
    check("R3", "irq_tx after set", int'(irq_tx), 1);
    drv('0, '0, '0, '0, '0, '0, 0, 1);
    check("R5", "vec tx line2", int'(vec_out), 'h054);
    drv('0, '0, '0, '0, '0, '0, 0, 1);
    check("R5", "vec tx line9", int'(vec_out), 'h08C);
    check("R5", "irq_tx cleared", int'(irq_tx), 0);

    // R6: empty acknowledges.
    drv('0, '0, '0, '0, '0, '0, 1, 0);
    check("R6", "empty rx vec", int'(vec_out), 0);
    check("R6", "empty rx valid", int'(vec_valid), 0);
    drv('0, '0, '0, '0, '0, '0, 0, 1);
    check("R6", "empty tx valid", int'(vec_valid), 0);

    // R8: clear wins over set, from a strobe or from an acknowledge.
    drv(16'h0002, '0, '0, 16'h0002, '0, '0, 0, 0);
    check("R8", "set+clr leaves clear", int'(irq_rx), 0);
    drv(16'h0002, '0, '0, '0, '0, '0, 0, 0);
    check("R2", "line1 set", int'(irq_rx), 1);
    drv(16'h0002, '0, '0, '0, '0, '0, 1, 0);
    check("R8", "ack beats set vec", int'(vec_out), 'h048);
    check("R8", "ack beats set irq", int'(irq_rx), 0);

    // R9: simultaneous acknowledges serve receive only.
    drv(16'h0010, '0, 16'h0001, '0, '0, '0, 0, 0);
    drv('0, '0, '0, '0, '0, '0, 1, 1);
    check("R9", "rx served", int'(vec_out), 'h060);
    check("R9", "tx kept", int'(irq_tx), 1);
    drv('0, '0, '0, '0, '0, '0, 0, 1);
    check("R9", "tx served later", int'(vec_out), 'h044);

    // R4 / R5: top line with a base that wraps.
    @(negedge clk); vec_base = 9'h1F8;
    drv('0, 16'h8000, 16'h8000, '0, '0, '0, 0, 0);
    drv('0, '0, '0, '0, '0, '0, 0, 1);
    check("R5", "wrap tx line15", int'(vec_out), 'h074);
    drv('0, '0, '0, '0, '0, '0, 1, 0);
    check("R4", "wrap rx line15", int'(vec_out), 'h070);

    // Mixed random traffic against the model.
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] a, b, d, e, f, g;
      a = N'($urandom & $urandom & $urandom);
      b = N'($urandom & $urandom & $urandom);
      d = N'($urandom & $urandom & $urandom);
      e = N'($urandom & $urandom & $urandom & $urandom);
      f = N'($urandom & $urandom & $urandom & $urandom);
      g = N'($urandom & $urandom & $urandom & $urandom);
      if (($urandom % 50) == 0) begin
        @(negedge clk); vec_base = VW'($urandom);
      end
      drv(a, b, d, e, f, g, ($urandom % 3) == 0, ($urandom % 3) == 0);
    end
    idle();
    finish_run();
  end

endmodule